// File: doc/BRIEF.md
# Agreeing-Sample Counter Snapshot Reader

This block gives logic in one clock domain a coherent copy of a free-running binary counter that ticks in another, faster and unrelated, clock domain. It uses no gray coding and no request/acknowledge crossing. Every counter bit goes through a two-flop synchronizer. A small sequencer then samples the synchronized value once per reader cycle and accepts it only when two samples in a row are equal.

The fastest `DROP_W` counter bits play no part in the comparison and always read as zero. The rest of the value therefore moves only once every `2**DROP_W` counter ticks. When that interval is longer than a reader cycle, a result is found within three samples.

A consumer pulses `rd_req`. It then waits for the single-cycle `rd_valid` pulse and takes `rd_data`. A request made while a read is running is remembered and served once the running read has delivered its result. `dbg_tries` shows how many samples the latest sequence has taken.

Top module: `cnt_snap_reader`

## Requirements
- R1: While reset is asserted and on release, `rd_valid` is 0, `rd_busy` is 0, `dbg_tries` is 0 and `rd_data` is 0.
- R2: A result is accepted only when two consecutive synchronized samples agree. If the counter has been steady for at least three reader cycles, `rd_valid` is observed three cycles after the request is driven: the request is taken on edge E0 and `rd_valid` is high after edge E2. `rd_data` equals the counter value.
- R3: Bits [DROP_W-1:0] of `rd_data` are always 0. Activity confined to those bits neither delays a result nor alters it.
- R4: Each accepted request clears the stored previous sample, so a result always needs at least two fresh samples. If the counter changes on the same cycle as the request, the old value is not returned. The new value arrives after three samples, four cycles after the request.
- R5: While the masked counter value changes every reader cycle, no result is given. Once it settles, the settled value is returned.
- R6: `rd_valid` is high for exactly one cycle per result. `rd_data` holds its value until the next result.
- R7: `rd_busy` is high from the cycle after a request is accepted until the result is delivered.
- R8: Requests made while busy are held and start exactly one further read after the current result. Several such requests merge into one.
- R9: `dbg_tries` counts the samples taken by the current or latest sequence. It saturates at 2**TRY_W-1.
- R10: If the counter advances by one per reader cycle and DROP_W is 2, the result comes with `dbg_tries` at most 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reader clock |
| rst_n | input | 1 | Active-low reset, reader domain |
| cnt_in | input | CNT_W | Raw counter value from the foreign domain |
| rd_req | input | 1 | Snapshot request |
| rd_valid | output | 1 | One-cycle result pulse |
| rd_data | output | CNT_W | Accepted snapshot, low DROP_W bits zero |
| rd_busy | output | 1 | A sampling sequence is running |
| dbg_tries | output | TRY_W | Samples taken in the current or latest sequence |

## Verification
Suppose a stale previous sample survived into a new sequence. That would show as a result two cycles too early, or as an old value with `dbg_tries` below 2, on the first read after the counter moves. A broken comparison mask shows up at once, in the latency of reads taken while only the low bits toggle, or as nonzero low data bits. A lost or duplicated pending request changes the count of `rd_valid` pulses within about ten cycles of a back-to-back request. A wrong saturation shows up as the value of `dbg_tries` after a long unsettled stretch.

// File: rtl/cnt_snap_pkg.sv
package cnt_snap_pkg;
  typedef enum logic [0:0] {
    SEQ_IDLE   = 1'b0,
    SEQ_SAMPLE = 1'b1
  } seq_state_e;
endpackage

// File: rtl/cnt_snap_sync.sv
// Two-stage synchronizer bank, one chain per counter bit.
module cnt_snap_sync #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1[i] <= 1'b0;
        q[i]      <= 1'b0;
      end else begin
        stage1[i] <= d[i];
        q[i]      <= stage1[i];
      end
    end
  end
endmodule

// File: rtl/cnt_snap_gate.sv
// Request admission with a single pending slot.
module cnt_snap_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_req,
  input  logic seq_idle,
  output logic start
);
  logic pending;
  assign start = seq_idle & (rd_req | pending);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   pending <= 1'b0;
    else if (start)               pending <= 1'b0;
    else if (rd_req && !seq_idle) pending <= 1'b1;
  end
endmodule

// File: rtl/cnt_snap_seq.sv
// Sampling sequencer: accept when two consecutive masked samples agree.
module cnt_snap_seq
  import cnt_snap_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DROP_W = 2,
  parameter int TRY_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] smp_raw,
  output logic [CNT_W-1:0] smp_masked,
  output logic             match_evt,
  output logic             seq_idle,
  output logic             rd_valid,
  output logic [CNT_W-1:0] rd_data,
  output logic [TRY_W-1:0] tries
);
  localparam logic [CNT_W-1:0] LOW_ONES  = CNT_W'((64'd1 << DROP_W) - 64'd1);
  localparam logic [CNT_W-1:0] KEEP_MASK = ~LOW_ONES;
  localparam logic [TRY_W-1:0] TRY_MAX   = {TRY_W{1'b1}};

  function automatic logic [CNT_W-1:0] drop_low(input logic [CNT_W-1:0] v);
    return v & KEEP_MASK;
  endfunction

  function automatic logic [TRY_W-1:0] sat_inc(input logic [TRY_W-1:0] v);
    return (v == TRY_MAX) ? v : v + TRY_W'(1);
  endfunction

  seq_state_e       state;
  logic [CNT_W-1:0] prev;
  logic             prev_ok;

  assign smp_masked = drop_low(smp_raw);
  assign seq_idle   = (state == SEQ_IDLE);
  assign match_evt  = (state == SEQ_SAMPLE) && prev_ok && (smp_masked == prev);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= SEQ_IDLE;
      prev     <= '0;
      prev_ok  <= 1'b0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
      tries    <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (start) begin
        state   <= SEQ_SAMPLE;
        prev_ok <= 1'b0;
        tries   <= '0;
      end else if (state == SEQ_SAMPLE) begin
        tries   <= sat_inc(tries);
        prev    <= smp_masked;
        prev_ok <= 1'b1;
        if (match_evt) begin
          rd_valid <= 1'b1;
          rd_data  <= smp_masked;
          state    <= SEQ_IDLE;
        end
      end
    end
  end
endmodule

// File: rtl/cnt_snap_reader.sv
module cnt_snap_reader #(
  parameter int CNT_W  = 16,
  parameter int DROP_W = 2,
  parameter int TRY_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic             rd_req,
  output logic             rd_valid,
  output logic [CNT_W-1:0] rd_data,
  output logic             rd_busy,
  output logic [TRY_W-1:0] dbg_tries
);
  logic [CNT_W-1:0] smp_raw;
  logic [CNT_W-1:0] smp_masked;
  logic             match_evt;
  logic             seq_idle;
  logic             seq_start;

  cnt_snap_sync #(.W(CNT_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(cnt_in), .q(smp_raw)
  );

  cnt_snap_gate u_gate (
    .clk(clk), .rst_n(rst_n), .rd_req(rd_req),
    .seq_idle(seq_idle), .start(seq_start)
  );

  cnt_snap_seq #(.CNT_W(CNT_W), .DROP_W(DROP_W), .TRY_W(TRY_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(seq_start),
    .smp_raw(smp_raw), .smp_masked(smp_masked), .match_evt(match_evt),
    .seq_idle(seq_idle), .rd_valid(rd_valid), .rd_data(rd_data),
    .tries(dbg_tries)
  );

  assign rd_busy = ~seq_idle;
endmodule

// File: rtl/cnt_snap_reader_chk.sv
module cnt_snap_reader_chk #(
  parameter int CNT_W  = 16,
  parameter int DROP_W = 2,
  parameter int TRY_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rd_valid,
  input logic [CNT_W-1:0] rd_data,
  input logic             rd_busy,
  input logic [TRY_W-1:0] dbg_tries,
  input logic [CNT_W-1:0] smp,
  input logic             match_evt,
  input logic             start
);
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);
  a_r6_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable(rd_data));
  a_r3_low_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_data[DROP_W-1:0] == '0));
  a_r2_match_first: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(match_evt));
  a_r2_data_from_sample: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_data == $past(smp)));
  a_r4_two_samples: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (dbg_tries >= TRY_W'(2)));
  a_r7_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> rd_busy);
endmodule

bind cnt_snap_reader cnt_snap_reader_chk #(
  .CNT_W(CNT_W), .DROP_W(DROP_W), .TRY_W(TRY_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_valid(rd_valid), .rd_data(rd_data),
  .rd_busy(rd_busy), .dbg_tries(dbg_tries), .smp(smp_masked),
  .match_evt(match_evt), .start(seq_start)
);

// File: tb/cnt_snap_reader_test.sv
`timescale 1ns/1ps
module cnt_snap_reader_test;
  localparam int W = 16;
  localparam int TW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [W-1:0]  raw = '0;
  logic          rd_req = 1'b0;
  logic          rd_valid;
  logic [W-1:0]  rd_data;
  logic          rd_busy;
  logic [TW-1:0] dbg_tries;

  int checks = 0;
  int errors = 0;
  int mode = 0;          // 0 hold, 1 add inc_val, 2 flip low bits
  logic [W-1:0] inc_val = 16'd1;
  int vcount = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cnt_snap_reader #(.CNT_W(W), .DROP_W(2), .TRY_W(TW)) uut (
    .clk(clk), .rst_n(rst_n), .cnt_in(raw), .rd_req(rd_req),
    .rd_valid(rd_valid), .rd_data(rd_data), .rd_busy(rd_busy),
    .dbg_tries(dbg_tries)
  );

  initial forever begin
    @(negedge clk);
    if (mode == 1) raw = raw + inc_val;
    else if (mode == 2) raw = raw ^ 16'h0003;
    if (rd_valid) vcount++;
  end

  localparam int NV = 6;
  localparam logic [W-1:0] V_RAW [NV] = '{16'h0000, 16'h0003, 16'h1235, 16'hFFFF, 16'h8002, 16'h7FFD};
  localparam logic [W-1:0] V_EXP [NV] = '{16'h0000, 16'h0000, 16'h1234, 16'hFFFC, 16'h8000, 16'h7FFC};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // Pulse a request and return the negedge count until rd_valid appears.
  task automatic do_read(output int lat);
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    lat = 1;
    check(rd_busy == 1'b1, "R7", int'(rd_busy), 1);
    while (!rd_valid && lat < 300) begin
      @(negedge clk); lat++;
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
    finish_run();
  end

  initial begin
    int lat;
    logic [W-1:0] keep;
    settle(3);
    check(rd_valid == 0 && rd_busy == 0 && dbg_tries == 0 && rd_data == 0,
          "R1", {rd_valid, rd_busy, dbg_tries}, 0);
    rst_n = 1'b1;
    settle(1);
    check(rd_valid == 0 && rd_busy == 0 && rd_data == 0, "R1", int'(rd_data), 0);

    // Table walk: steady counter values (R2, R3, R9)
    for (int i = 0; i < NV; i++) begin
      raw = V_RAW[i];
      settle(4);
      do_read(lat);
      check(lat == 3, "R2", lat, 3);
      check(rd_data == V_EXP[i], "R2", int'(rd_data), int'(V_EXP[i]));
      check(rd_data[1:0] == 2'b00, "R3", int'(rd_data[1:0]), 0);
      check(dbg_tries == 2, "R9", int'(dbg_tries), 2);
    end

    // R6: data held and no further pulse
    keep = rd_data;
    settle(1);
    check(rd_valid == 1'b0, "R6", int'(rd_valid), 0);
    settle(5);
    check(rd_data == keep, "R6", int'(rd_data), int'(keep));
    check(rd_busy == 1'b0, "R7", int'(rd_busy), 0);

    // R4: counter changes on the request cycle
    @(negedge clk);
    raw = 16'h4444; rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0; lat = 1;
    while (!rd_valid && lat < 300) begin @(negedge clk); lat++; end
    check(lat == 4, "R4", lat, 4);
    check(rd_data == 16'h4444, "R4", int'(rd_data), 16'h4444);
    check(dbg_tries == 3, "R4", int'(dbg_tries), 3);

    // R3: low-bit toggling does not delay or alter the result
    raw = 16'h5A5B;
    settle(4);
    mode = 2;
    do_read(lat);
    check(lat == 3, "R3", lat, 3);
    check(rd_data == 16'h5A58, "R3", int'(rd_data), 16'h5A58);
    mode = 0;

    // R5 and R9: masked value moves every cycle, then settles
    settle(2);
    inc_val = 16'd4; mode = 1;
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    vcount = 0;
    settle(24);
    check(vcount == 0 && rd_busy == 1'b1, "R5", vcount, 0);
    mode = 0;
    keep = raw;
    lat = 0;
    while (!rd_valid && lat < 300) begin @(negedge clk); lat++; end
    check(rd_valid == 1'b1 && rd_data == {keep[W-1:2], 2'b00}, "R5", int'(rd_data), int'({keep[W-1:2], 2'b00}));
    check(dbg_tries == 4'hF, "R9", int'(dbg_tries), 15);

    // R10: counter advancing by one per cycle settles within three samples
    inc_val = 16'd1;
    for (int k = 0; k < 4; k++) begin
      mode = 1;
      settle(k + 1);
      do_read(lat);
      check(rd_valid == 1'b1 && dbg_tries <= 3, "R10", int'(dbg_tries), 3);
      check(rd_data[1:0] == 2'b00, "R3", int'(rd_data[1:0]), 0);
    end
    mode = 0;

    // R8: request while busy starts exactly one more read
    raw = 16'h2468;
    settle(4);
    vcount = 0;
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    settle(12);
    check(vcount == 2, "R8", vcount, 2);
    check(rd_data == 16'h2468 && rd_busy == 1'b0, "R8", int'(rd_data), 16'h2468);

    // R1: reset mid-read clears everything
    @(negedge clk); rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
    rst_n = 1'b0;
    settle(2);
    check(rd_busy == 0 && rd_valid == 0 && dbg_tries == 0 && rd_data == 0, "R1", int'(rd_data), 0);
    rst_n = 1'b1;
    settle(2);
    finish_run();
  end
endmodule